// File: doc/BRIEF.md
# Signaling Change-of-State Detector

This block tracks the four-bit signaling code of every channel on a framed line of 24 or 32 channels. An upstream extractor hands over per-channel nibbles with a strobe, and the block holds the most recent one for each channel in a staging register. A multiframe boundary pulse makes every channel compare its staged nibble with its stored signaling state. When the two differ, the stored state is updated and a per-channel change bit is raised.

An optional global integration filter delays every update until the new code has been seen at three boundaries in a row. Change bits are raised for every channel. A separate per-channel select mask decides which channels can set a single latched summary flag. The summary flag, qualified by an interrupt mask bit, drives an active-low interrupt. Software clears the change bits and the summary flag with a write-one-to-clear.

Top module: `sig_cos_detector`

## Requirements
- R1: The stored signaling output `sig_store` (channel c at bits 4c+3..4c) changes only in the cycle after `mf_tick`. The value compared at a boundary is the last nibble strobed for that channel before the cycle of the pulse. A strobe in the same cycle as the pulse is kept for the next boundary.
- R2: The first `mf_tick` after reset loads every staged nibble into `sig_store` as the baseline. It sets no status bit and does not set the summary flag.
- R3: With `integ_en` low, a channel whose staged nibble differs from its stored value at a boundary takes the staged value. Its bit c of `cos_status` reads 1 from the next cycle on.
- R4: With `integ_en` high, which applies to all channels at once, a differing nibble is accepted only when the same value is present at three consecutive boundaries. A different value starts the count again. A return to the stored value cancels the pending change.
- R5: `cos_status` records every change whatever `chan_sel` holds. `cos_summary` is set only by a change on a channel whose `chan_sel` bit is 1.
- R6: When `clr_valid` is high, each `cos_status` bit with a 1 in `clr_chan` is cleared, and `cos_summary` is cleared if `clr_summary` is 1. A change in the same cycle as the clear wins, and its bit stays set.
- R7: `irq_n` is 0 exactly when `cos_summary` is 1 and `irq_mask` is 1. Otherwise it is 1.
- R8: While reset is active and after it is released, `sig_store`, `cos_status` and `cos_summary` are all zero and `irq_n` is 1 until the first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_valid | input | 1 | Strobe for a new channel nibble |
| sig_chan | input | CHW | Binary channel number of the strobed nibble |
| sig_data | input | 4 | Signaling nibble |
| mf_tick | input | 1 | Multiframe boundary pulse, one cycle |
| integ_en | input | 1 | Global three-boundary integration enable |
| chan_sel | input | NCH | Channels allowed to set the summary flag |
| irq_mask | input | 1 | 1 lets the summary flag drive the interrupt |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_chan | input | NCH | Status bits to clear |
| clr_summary | input | 1 | Clear the summary flag |
| sig_store | output | 4*NCH | Stored signaling, nibble per channel |
| cos_status | output | NCH | Per-channel change bits |
| cos_summary | output | 1 | Latched summary change flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `mf_tick` is a one-cycle pulse separated from the next by idle cycles. They also assume that the only changes to the stored state happen at those pulses. The rule that a new bit appears only after a boundary depends on this. The stimulus raises `mf_tick` for a single cycle at a time and never together with a strobe unless a test targets that overlap. Clears are issued only in cycles of their own, except in the test of a clear landing on a boundary.

// File: rtl/sigcos_pkg.sv
package sigcos_pkg;
  localparam int NIB_W     = 4;
  localparam int INTEG_LEN = 3;
  localparam int ICNT_W    = $clog2(INTEG_LEN + 1);
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [ICNT_W-1:0] icnt_t;
endpackage

// File: rtl/sigcos_stage.sv
module sigcos_stage
  import sigcos_pkg::*;
#(
  parameter int NCH = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_valid,
  input  logic [CHW-1:0]       sig_chan,
  input  nib_t                 sig_data,
  output logic [NCH*NIB_W-1:0] staged
);
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    nib_t lane_q, lane_n;
    logic hit;

    always_comb begin
      hit    = sig_valid && (sig_chan == CHW'(c));
      lane_n = hit ? sig_data : lane_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else if (hit) lane_q <= lane_n;
    end

    assign staged[c*NIB_W +: NIB_W] = lane_q;
  end
endmodule

// File: rtl/sigcos_chan.sv
module sigcos_chan
  import sigcos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic primed,
  input  logic integ_en,
  input  nib_t staged,
  output nib_t stored,
  output logic chg
);
  nib_t  st_q, st_n, cand_q, cand_n;
  icnt_t cnt_q, cnt_n;

  always_comb begin
    st_n   = st_q;
    cand_n = cand_q;
    cnt_n  = cnt_q;
    chg    = 1'b0;
    if (tick) begin
      if (!primed) begin
        st_n   = staged;
        cand_n = staged;
        cnt_n  = '0;
      end else if (staged == st_q) begin
        cand_n = staged;
        cnt_n  = '0;
      end else if (!integ_en) begin
        st_n   = staged;
        cand_n = staged;
        cnt_n  = '0;
        chg    = 1'b1;
      end else if ((staged != cand_q) || (cnt_q == '0)) begin
        cand_n = staged;
        cnt_n  = icnt_t'(1);
      end else if (cnt_q == icnt_t'(INTEG_LEN - 1)) begin
        st_n   = staged;
        cnt_n  = '0;
        chg    = 1'b1;
      end else begin
        cnt_n  = cnt_q + icnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (tick) begin
      st_q   <= st_n;
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
    end
  end

  assign stored = st_q;
endmodule

// File: rtl/sigcos_flags.sv
module sigcos_flags #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chg,
  input  logic [NCH-1:0] chan_sel,
  input  logic           clr_valid,
  input  logic [NCH-1:0] clr_chan,
  input  logic           clr_summary,
  input  logic           irq_mask,
  output logic [NCH-1:0] status,
  output logic           summary,
  output logic           irq_n
);
  logic [NCH-1:0] stat_q, stat_n, wipe;
  logic           sum_q, sum_n, sum_wipe, sum_set;

  always_comb begin
    wipe     = clr_valid ? clr_chan : '0;
    sum_wipe = clr_valid && clr_summary;
    sum_set  = |(chg & chan_sel);
    stat_n   = (stat_q & ~wipe) | chg;
    sum_n    = (sum_q && !sum_wipe) || sum_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      sum_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      sum_q  <= sum_n;
    end
  end

  assign status  = stat_q;
  assign summary = sum_q;
  assign irq_n   = !(sum_q && irq_mask);
endmodule

// File: rtl/sig_cos_detector.sv
module sig_cos_detector
  import sigcos_pkg::*;
#(
  parameter int NCH = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sig_valid,
  input  logic [CHW-1:0]       sig_chan,
  input  logic [NIB_W-1:0]     sig_data,
  input  logic                 mf_tick,
  input  logic                 integ_en,
  input  logic [NCH-1:0]       chan_sel,
  input  logic                 irq_mask,
  input  logic                 clr_valid,
  input  logic [NCH-1:0]       clr_chan,
  input  logic                 clr_summary,
  output logic [NCH*NIB_W-1:0] sig_store,
  output logic [NCH-1:0]       cos_status,
  output logic                 cos_summary,
  output logic                 irq_n
);
  logic [NCH*NIB_W-1:0] staged;
  logic [NCH-1:0]       chg;
  logic                 primed_q, primed_n;

  always_comb primed_n = primed_q || mf_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= primed_n;
  end

  sigcos_stage #(.NCH(NCH), .CHW(CHW)) u_stage (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid),
    .sig_chan(sig_chan), .sig_data(sig_data), .staged(staged)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sigcos_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick(mf_tick), .primed(primed_q),
      .integ_en(integ_en), .staged(staged[c*NIB_W +: NIB_W]),
      .stored(sig_store[c*NIB_W +: NIB_W]), .chg(chg[c])
    );
  end

  sigcos_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .chg(chg), .chan_sel(chan_sel),
    .clr_valid(clr_valid), .clr_chan(clr_chan), .clr_summary(clr_summary),
    .irq_mask(irq_mask), .status(cos_status), .summary(cos_summary),
    .irq_n(irq_n)
  );
endmodule

// File: rtl/sigcos_chk.sv
module sigcos_chk #(
  parameter int NCH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mf_tick,
  input logic             irq_mask,
  input logic             clr_valid,
  input logic [NCH-1:0]   clr_chan,
  input logic [NCH*4-1:0] sig_store,
  input logic [NCH-1:0]   cos_status,
  input logic             cos_summary,
  input logic             irq_n
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (mf_tick) seen_q <= 1'b1;
  end

  a_r1_store_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_tick |=> $stable(sig_store));

  a_r2_baseline_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_tick && !seen_q) |=> ((cos_status == '0) && !cos_summary));

  a_r3_status_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_tick |=> ((cos_status & ~$past(cos_status)) == '0));

  a_r5_summary_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cos_summary) |-> $past(mf_tick));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !mf_tick) |=> ((cos_status & $past(clr_chan)) == '0));

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> irq_n);

  a_r7_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_summary && irq_mask) |-> !irq_n);
endmodule

bind sig_cos_detector sigcos_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mf_tick(mf_tick), .irq_mask(irq_mask),
  .clr_valid(clr_valid), .clr_chan(clr_chan), .sig_store(sig_store),
  .cos_status(cos_status), .cos_summary(cos_summary), .irq_n(irq_n)
);

// File: tb/sig_cos_detector_tb.sv
module sig_cos_detector_tb;
  localparam int NCH = 32;
  localparam int CHW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_valid = 1'b0;
  logic [CHW-1:0] sig_chan = '0;
  logic [3:0] sig_data = '0;
  logic mf_tick = 1'b0, integ_en = 1'b0, irq_mask = 1'b0;
  logic [NCH-1:0] chan_sel = '0, clr_chan = '0;
  logic clr_valid = 1'b0, clr_summary = 1'b0;
  logic [NCH*4-1:0] sig_store;
  logic [NCH-1:0] cos_status;
  logic cos_summary, irq_n;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sig_cos_detector #(.NCH(NCH), .CHW(CHW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_chan(sig_chan),
    .sig_data(sig_data), .mf_tick(mf_tick), .integ_en(integ_en),
    .chan_sel(chan_sel), .irq_mask(irq_mask), .clr_valid(clr_valid),
    .clr_chan(clr_chan), .clr_summary(clr_summary), .sig_store(sig_store),
    .cos_status(cos_status), .cos_summary(cos_summary), .irq_n(irq_n)
  );

  // behavioural reference
  int m_stage[NCH], m_store[NCH], m_cand[NCH], m_cnt[NCH];
  bit m_stat[NCH];
  bit m_sum, m_primed;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_stage[c] = 0; m_store[c] = 0; m_cand[c] = 0; m_cnt[c] = 0; m_stat[c] = 0;
      end
      m_sum = 0; m_primed = 0;
    end else begin
      bit chg[NCH];
      bit any_sel;
      any_sel = 0;
      for (int c = 0; c < NCH; c++) begin
        int s;
        chg[c] = 0;
        s = m_stage[c];
        if (mf_tick) begin
          if (!m_primed) begin m_store[c] = s; m_cand[c] = s; m_cnt[c] = 0; end
          else if (s == m_store[c]) begin m_cand[c] = s; m_cnt[c] = 0; end
          else if (!integ_en) begin m_store[c] = s; m_cand[c] = s; m_cnt[c] = 0; chg[c] = 1; end
          else if (s != m_cand[c] || m_cnt[c] == 0) begin m_cand[c] = s; m_cnt[c] = 1; end
          else if (m_cnt[c] == 2) begin m_store[c] = s; m_cnt[c] = 0; chg[c] = 1; end
          else m_cnt[c] = m_cnt[c] + 1;
        end
        if (clr_valid && clr_chan[c]) m_stat[c] = 0;
        if (chg[c]) begin
          m_stat[c] = 1;
          if (chan_sel[c]) any_sel = 1;
        end
      end
      if (mf_tick) m_primed = 1;
      if (clr_valid && clr_summary) m_sum = 0;
      if (any_sel) m_sum = 1;
      if (sig_valid && int'(sig_chan) < NCH) m_stage[sig_chan] = int'(sig_data);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      logic [NCH*4-1:0] e_store;
      logic [NCH-1:0] e_stat;
      for (int c = 0; c < NCH; c++) begin
        e_store[c*4 +: 4] = 4'(m_store[c]);
        e_stat[c] = m_stat[c];
      end
      chk(sig_store == e_store, "R1 model store", 128'(sig_store), 128'(e_store));
      chk(cos_status == e_stat, "R3 model status", 128'(cos_status), 128'(e_stat));
      chk(cos_summary == m_sum, "R5 model summary", 128'(cos_summary), 128'(m_sum));
      chk(irq_n == !(m_sum && irq_mask), "R7 model irq", 128'(irq_n), 128'(!(m_sum && irq_mask)));
    end
  end

  function automatic logic [3:0] nib(input int c);
    return sig_store[c*4 +: 4];
  endfunction

  task automatic strobe(input int ch, input logic [3:0] v);
    @(negedge clk);
    sig_valid = 1'b1; sig_chan = CHW'(ch); sig_data = v;
    @(negedge clk);
    sig_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    mf_tick = 1'b1;
    @(negedge clk);
    mf_tick = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_valid = 1'b1; clr_chan = '1; clr_summary = 1'b1;
    @(negedge clk);
    clr_valid = 1'b0; clr_chan = '0; clr_summary = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sig_store == '0 && cos_status == '0 && !cos_summary && irq_n, "R8 in reset",
        128'(sig_store), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cos_status == '0 && irq_n, "R8 after release", 128'(cos_status), 128'(0));

    // baseline
    for (int c = 0; c < NCH; c++) strobe(c, 4'(c));
    tick();
    chk(nib(5) == 4'h5, "R2 baseline load", 128'(nib(5)), 128'(5));
    chk(cos_status == '0 && !cos_summary, "R2 baseline quiet", 128'(cos_status), 128'(0));

    // R1: strobe without boundary leaves store alone
    strobe(5, 4'hF);
    repeat (3) @(negedge clk);
    chk(nib(5) == 4'h5, "R1 no update between ticks", 128'(nib(5)), 128'(5));

    // R3 / R5 / R7 direct mode
    strobe(3, 4'hA);
    strobe(7, 4'h0);
    chan_sel = 32'h0000_0080;
    tick();
    chk(cos_status == 32'h0000_00A8, "R3 status bits", 128'(cos_status), 128'h A8);
    chk(nib(3) == 4'hA && nib(7) == 4'h0, "R3 store update", 128'(nib(3)), 128'hA);
    chk(cos_summary, "R5 selected channel sets summary", 128'(cos_summary), 128'(1));
    chk(irq_n, "R7 masked irq", 128'(irq_n), 128'(1));
    @(negedge clk); irq_mask = 1'b1;
    @(negedge clk);
    chk(!irq_n, "R7 irq asserted", 128'(irq_n), 128'(0));

    clear_all();
    chk(cos_status == '0 && !cos_summary && irq_n, "R6 clear", 128'(cos_status), 128'(0));

    // R5: unselected change
    strobe(3, 4'hB);
    tick();
    chk(cos_status == 32'h8 && !cos_summary, "R5 unselected no summary",
        128'(cos_summary), 128'(0));

    // R6: change lands with clear
    strobe(3, 4'hC);
    strobe(7, 4'h1);
    @(negedge clk);
    mf_tick = 1'b1; clr_valid = 1'b1; clr_chan = '1; clr_summary = 1'b1;
    @(negedge clk);
    mf_tick = 1'b0; clr_valid = 1'b0; clr_chan = '0; clr_summary = 1'b0;
    chk(cos_status == 32'h88 && cos_summary, "R6 change wins over clear",
        128'(cos_status), 128'h88);

    // R4 integration
    clear_all();
    integ_en = 1'b1;
    strobe(10, 4'h3);
    tick(); tick();
    chk(nib(10) == 4'hA && cos_status == '0, "R4 held after two", 128'(nib(10)), 128'hA);
    tick();
    chk(nib(10) == 4'h3 && cos_status == 32'h400, "R4 accepted on third",
        128'(nib(10)), 128'h3);

    clear_all();
    strobe(11, 4'h1);
    tick();
    strobe(11, 4'h2);
    tick(); tick();
    chk(nib(11) == 4'hB, "R4 restart on new value", 128'(nib(11)), 128'hB);
    tick();
    chk(nib(11) == 4'h2 && cos_status == 32'h800, "R4 accepted after restart",
        128'(nib(11)), 128'h2);

    clear_all();
    strobe(12, 4'h0);
    tick();
    strobe(12, 4'hC);
    tick(); tick(); tick();
    chk(nib(12) == 4'hC && cos_status == '0, "R4 cancel on return",
        128'(cos_status), 128'(0));

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule